// File: doc/BRIEF.md
# Multi-scheme PWM edge generator

The block turns a ramp count and a duty word into one PWM output. A ramp counter outside the block counts `cnt_i` from 0 to `cnt_max_i - 1` and then wraps to 0. The duty word `duty_i` is a fraction of the ramp period, where the value 256 means full scale. The block converts it into an on-width `W = floor(duty * cnt_max / 256)` counts. It then places that window inside the period in one of three ways:

- **trailing-edge:** the window starts at the beginning of the period;
- **leading-edge:** the window ends at the end of the period;
- **dual-edge:** the window is centred in the period.

An invert control drives the complement of the window instead. The rising edge then sits where the window closes and the falling edge where it opens, so the width is `cnt_max - W`.

The duty word, the mode and the invert control are double-buffered. They are sampled only on the last count of a period and apply from count 0 of the next one, so a change made mid-period never produces a runt pulse. Along with the PWM level, the block produces single-cycle strobes that mark rising and falling edges. Two ramps with their own settings are served by two instances.

Top module: `pwm_edge_gen`

## Requirements
- R1: While reset is asserted and after it is released, `pwm_o`, `le_o` and `te_o` are 0. The active settings reset to duty 0, dual-edge mode and no invert, so the output stays low until the first wrap loads new settings.
- R2: Mode 2 and mode 3 both select trailing-edge modulation. The window is high for counts `0 <= cnt < W`.
- R3: Mode 1 selects leading-edge modulation. The window is high for counts `cnt_max - W <= cnt < cnt_max`.
- R4: Mode 0 selects dual-edge modulation. The window is high for counts `floor((cnt_max - W)/2) <= cnt < floor((cnt_max + W)/2)`.
- R5: With invert set to 1, `pwm_o` is the complement of the window. It is high outside the window, for `cnt_max - W` counts per period.
- R6: `duty_i`, `mode_i` and `invert_i` are sampled only in the cycle where `cnt_i == cnt_max_i - 1`, and they take effect from the following count 0. Values presented in any other cycle have no effect on the output.
- R7: Duty 0 gives a constant output, low (or high when inverted). Duty of 256 or more saturates to full scale and gives a constant high output (low when inverted). Neither case produces an edge strobe, including across the period wrap.
- R8: `pwm_o` is registered: its value in a cycle follows from the `cnt_i` of the previous cycle. `le_o` is 1 for exactly the cycle in which `pwm_o` goes 0→1, and `te_o` for exactly the cycle in which it goes 1→0. The two strobes are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| duty_i | input | DUTY_W+1 | Duty fraction, full scale = 2^DUTY_W; larger values saturate |
| mode_i | input | 2 | 0 dual-edge, 1 leading-edge, 2/3 trailing-edge |
| invert_i | input | 1 | 1 drives the complementary pulse |
| cnt_i | input | CNT_W | Ramp count, runs 0 to cnt_max_i-1 |
| cnt_max_i | input | CNT_W | Ramp period in counts |
| pwm_o | output | 1 | PWM output (registered) |
| le_o | output | 1 | Rising-edge strobe |
| te_o | output | 1 | Falling-edge strobe |

## Verification
Between wraps the bench drives changing, unrelated values on the duty, mode and invert inputs. A design that latched them outside the last count would show edges that move within a period or runt pulses. The sequence covers the truncating centred placement with both odd and even `cnt_max - W`, which catches an off-by-one edge. It also steps through the inverted trailing-edge and leading-edge cases and the duty-0, full-scale and above-full-scale cases. In those cases a design that mishandles the wrap or saturation would emit a one-cycle glitch at count 0 together with a stray strobe. Strobes are checked against the previous expected level across period boundaries, so a strobe raised on a steady level is caught as well as a missing one.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {
    MOD_DUAL      = 2'd0,
    MOD_LEAD      = 2'd1,
    MOD_TRAIL     = 2'd2,
    MOD_TRAIL_ALT = 2'd3
  } mod_e;
endpackage

// File: rtl/pwm_shadow.sv
module pwm_shadow #(
  parameter int DUTY_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DUTY_W:0]   duty_i,
  input  logic [1:0]        mode_i,
  input  logic              invert_i,
  output logic [DUTY_W:0]   duty_o,
  output pwm_pkg::mod_e     mode_o,
  output logic              invert_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_o   <= '0;
      mode_o   <= pwm_pkg::MOD_DUAL;
      invert_o <= 1'b0;
    end else if (load_i) begin
      duty_o   <= duty_i;
      mode_o   <= pwm_pkg::mod_e'(mode_i);
      invert_o <= invert_i;
    end
  end

  // R6: settings move only at a wrap
  p_hold_mid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(load_i) |-> ($stable(duty_o) && $stable(mode_o) && $stable(invert_o)));
endmodule

// File: rtl/pwm_edge_calc.sv
module pwm_edge_calc #(
  parameter int CNT_W  = 8,
  parameter int DUTY_W = 8
) (
  input  logic [DUTY_W:0]  duty_i,
  input  pwm_pkg::mod_e    mode_i,
  input  logic [CNT_W-1:0] cnt_max_i,
  output logic [CNT_W:0]   t1_o,
  output logic [CNT_W:0]   t2_o
);
  localparam int          PROD_W = CNT_W + DUTY_W + 1;
  localparam logic [DUTY_W:0] FULL = (DUTY_W+1)'(1) << DUTY_W;

  logic [DUTY_W:0] duty_sat;
  logic [PROD_W-1:0] prod;
  logic [CNT_W:0]  width, max_x;

  always_comb begin
    duty_sat = (duty_i > FULL) ? FULL : duty_i;
    prod     = PROD_W'(duty_sat) * PROD_W'(cnt_max_i);
    width    = (CNT_W+1)'(prod >> DUTY_W);
    max_x    = {1'b0, cnt_max_i};
    unique case (mode_i)
      pwm_pkg::MOD_LEAD: begin
        t1_o = max_x - width;
        t2_o = max_x;
      end
      pwm_pkg::MOD_DUAL: begin
        t1_o = (max_x - width) >> 1;
        t2_o = (max_x + width) >> 1;
      end
      default: begin
        t1_o = '0;
        t2_o = width;
      end
    endcase
  end
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W:0]   t1_i,
  input  logic [CNT_W:0]   t2_i,
  input  logic             invert_i,
  output logic             pwm_o,
  output logic             le_o,
  output logic             te_o
);
  logic in_win, pwm_d;

  always_comb begin
    in_win = ({1'b0, cnt_i} >= t1_i) && ({1'b0, cnt_i} < t2_i);
    pwm_d  = in_win ^ invert_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwm_o <= 1'b0;
      le_o  <= 1'b0;
      te_o  <= 1'b0;
    end else begin
      pwm_o <= pwm_d;
      le_o  <= pwm_d & ~pwm_o;
      te_o  <= ~pwm_d & pwm_o;
    end
  end

  p_strobe_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(le_o && te_o));
  p_le_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    le_o |-> (pwm_o && !$past(pwm_o)));
  p_te_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    te_o |-> (!pwm_o && $past(pwm_o)));
endmodule

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen #(
  parameter int CNT_W  = 8,
  parameter int DUTY_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DUTY_W:0]   duty_i,
  input  logic [1:0]        mode_i,
  input  logic              invert_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  cnt_max_i,
  output logic              pwm_o,
  output logic              le_o,
  output logic              te_o
);
  logic            wrap;
  logic [DUTY_W:0] act_duty;
  pwm_pkg::mod_e   act_mode;
  logic            act_inv;
  logic [CNT_W:0]  t1, t2;

  assign wrap = (cnt_i == cnt_max_i - CNT_W'(1));

  pwm_shadow #(.DUTY_W(DUTY_W)) u_shadow (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (wrap),
    .duty_i   (duty_i),
    .mode_i   (mode_i),
    .invert_i (invert_i),
    .duty_o   (act_duty),
    .mode_o   (act_mode),
    .invert_o (act_inv)
  );

  pwm_edge_calc #(.CNT_W(CNT_W), .DUTY_W(DUTY_W)) u_calc (
    .duty_i    (act_duty),
    .mode_i    (act_mode),
    .cnt_max_i (cnt_max_i),
    .t1_o      (t1),
    .t2_o      (t2)
  );

  pwm_out_stage #(.CNT_W(CNT_W)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cnt_i    (cnt_i),
    .t1_i     (t1),
    .t2_i     (t2),
    .invert_i (act_inv),
    .pwm_o    (pwm_o),
    .le_o     (le_o),
    .te_o     (te_o)
  );

  // R4: edges ordered and inside the period
  p_edges_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t1 <= t2) && (t2 <= {1'b0, cnt_max_i}));
  // R7: empty window gives steady level on the next cycle
  p_zero_steady_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t1 == t2) |=> (pwm_o == $past(act_inv)));
endmodule

// File: tb/pwm_edge_gen_test.sv
module pwm_edge_gen_test;
  localparam int MAXC = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] duty = '0;
  logic [1:0] mode = '0;
  logic       inv = 1'b0;
  logic [7:0] cnt = '0;
  logic [7:0] cmax = 8'(MAXC);
  logic       pwm, le, te;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  typedef struct {
    bit    pwm;
    bit    le;
    bit    te;
    int    c;
    string tag;
  } item_t;
  item_t q[$];

  int    a_duty = 0, a_mode = 0;
  bit    a_inv = 0, prev_pwm = 0;
  string a_tag = "R1";

  always #2 clk = ~clk;

  pwm_edge_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .duty_i(duty), .mode_i(mode), .invert_i(inv),
    .cnt_i(cnt), .cnt_max_i(cmax), .pwm_o(pwm), .le_o(le), .te_o(te)
  );

  function automatic bit model(int c, int d, int m, bit iv, int mx);
    int ds, w, t1, t2;
    ds = (d > 256) ? 256 : d;
    w  = (ds * mx) / 256;
    case (m)
      1:       begin t1 = mx - w;       t2 = mx;           end
      0:       begin t1 = (mx - w) / 2; t2 = (mx + w) / 2; end
      default: begin t1 = 0;            t2 = w;            end
    endcase
    return ((c >= t1) && (c < t2)) ^ iv;
  endfunction

  // Driver: one ramp period; settings presented only on the last count
  task automatic run_period(int d, int m, bit iv, string tag);
    for (int c = 0; c < MAXC; c++) begin
      item_t it;
      bit p;
      @(negedge clk);
      cnt = 8'(c);
      if (c == MAXC - 1) begin
        duty = 9'(d); mode = 2'(m); inv = iv;
      end else begin
        duty = 9'((c * 37 + 11) % 512); mode = 2'(c % 4); inv = 1'(c % 2);
      end
      p = model(c, a_duty, a_mode, a_inv, MAXC);
      it.pwm = p; it.le = p & ~prev_pwm; it.te = ~p & prev_pwm;
      it.c = c; it.tag = a_tag;
      q.push_back(it);
      prev_pwm = p;
      if (c == MAXC - 1) begin
        a_duty = d; a_mode = m; a_inv = iv; a_tag = tag;
      end
    end
  endtask

  // Monitor
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t e;
      e = q.pop_front();
      checks++;
      if (pwm !== e.pwm || le !== e.le || te !== e.te) begin
        errors++;
        $display("FAIL %s (R6 latch, R8 strobes) cnt=%0d actual pwm/le/te=%b%b%b expected=%b%b%b",
                 e.tag, e.c, pwm, le, te, e.pwm, e.le, e.te);
      end
    end
  end

  initial begin
    #40000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (pwm !== 1'b0 || le !== 1'b0 || te !== 1'b0) begin
      errors++;
      $display("FAIL R1 in reset actual=%b%b%b expected=000", pwm, le, te);
    end
    rst_n = 1'b1;
    checks++;
    if (pwm !== 1'b0 || le !== 1'b0 || te !== 1'b0) begin
      errors++;
      $display("FAIL R1 after release actual=%b%b%b expected=000", pwm, le, te);
    end
    run_period(64, 2, 0, "R2");   // W=5
    run_period(128, 3, 0, "R2");  // W=10
    run_period(77, 1, 0, "R3");   // W=6
    run_period(100, 0, 0, "R4");  // W=7, edges 6..13
    run_period(128, 0, 0, "R4");  // W=10, edges 5..15
    run_period(64, 2, 1, "R5");
    run_period(77, 1, 1, "R5");
    run_period(0, 0, 0, "R7");
    run_period(256, 1, 0, "R7");
    run_period(256, 2, 0, "R7");
    run_period(300, 2, 0, "R7");
    run_period(256, 0, 1, "R7");
    run_period(0, 2, 1, "R7");
    run_period(100, 0, 0, "R6");
    run_period(0, 0, 0, "R6");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule